// File: doc/BRIEF.md
# Column Scan Compare Unit

This block scans the values of one attribute of a column-store table as they stream past and reduces them to a single answer. The host picks one of three reductions by writing an opcode: a membership test for a key, an occurrence count of a key, or the largest value in the range. Elements arrive as 64-bit unsigned words on a valid-qualified stream. The unit takes one element per clock cycle while it is busy and the stream is valid.

The host programs the opcode, the key and the number of elements through a small register window. It then writes a start bit and polls a status word until the done flag is set. After that it reads the hit flag, the count or the maximum. Fetching the data from memory happens outside this block.

Top module: `colscan_unit`

## Requirements
- R1: Every element, the key and the maximum are handled as 64-bit unsigned integers. An element with bit 63 set ranks above any element with bit 63 clear.
- R2: With opcode 2'b00 (hit), the hit register (address 5, bit 0) reads 1 after the scan only if an element equal to the key was consumed. Otherwise it reads 0.
- R3: With opcode 2'b01 (count), the count register (address 6) reads the number of consumed elements equal to the key.
- R4: With opcode 2'b10 (max), the maximum register (address 7) reads the largest consumed element.
- R5: Opcode 2'b11 is illegal. Writing start with it sets the error bit (status bit 2) and done in the next cycle. Busy is never set.
- R6: An accepted start clears the hit flag, the count, the maximum, done and error. A scan with an element count of 0 is done in the next cycle with all results 0.
- R7: While busy, one element is consumed on every clock edge where s_valid is high. A cycle with s_valid low consumes nothing. s_ready is high exactly while busy.
- R8: Busy rises on the edge that accepts start. Done and the final result appear on the same edge that consumes the last element. Busy falls on that edge too, and busy and done are never high together.
- R9: The count saturates at 2^CNT_W-1 instead of wrapping.
- R10: While busy, a write of start is ignored and the running scan goes on unchanged. Writes to the opcode, key and count registers are also ignored until the scan ends.
- R11: After reset, status, hit, count and maximum all read 0.
- R12: Register window, word addresses: 0 control (write bit 0 = start), 1 opcode (bits 1:0), 2 key, 3 element count (bits LEN_W-1:0), 4 status (bit 0 done, bit 1 busy, bit 2 error). Addresses 5, 6 and 7 hold the hit, count and maximum results. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register write word address |
| reg_wr_data | input | DATA_W | Register write data |
| reg_rd_addr | input | 3 | Register read word address |
| reg_rd_data | output | DATA_W | Register read data |
| s_valid | input | 1 | Element stream valid |
| s_data | input | DATA_W | Element value |
| s_ready | output | 1 | High while the unit consumes elements |

## Verification
A register write takes effect on the edge that samples it, so status and results are read half a cycle after that edge. Busy is read right after the start write. Done is read half a cycle after the edge that consumes the last element, and done is also checked to be still low just before that last element is driven. A zero-length or illegal start is checked half a cycle after the start edge. Stalled stream cycles move done later by one cycle each, and the bench feeds elements one per cycle so that it knows exactly which edge is the last.

// File: rtl/colscan_pkg.sv
package colscan_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [1:0] {
    OP_HIT = 2'b00,
    OP_CNT = 2'b01,
    OP_MAX = 2'b10,
    OP_BAD = 2'b11
  } scan_op_e;

  localparam logic [REG_AW-1:0] A_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] A_OP   = 3'd1;
  localparam logic [REG_AW-1:0] A_KEY  = 3'd2;
  localparam logic [REG_AW-1:0] A_LEN  = 3'd3;
  localparam logic [REG_AW-1:0] A_STAT = 3'd4;
  localparam logic [REG_AW-1:0] A_HIT  = 3'd5;
  localparam logic [REG_AW-1:0] A_CNT  = 3'd6;
  localparam logic [REG_AW-1:0] A_MAX  = 3'd7;
endpackage

// File: rtl/colscan_cfg.sv
module colscan_cfg
  import colscan_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LEN_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              lock,
  output scan_op_e          op,
  output logic [DATA_W-1:0] key,
  output logic [LEN_W-1:0]  len,
  output logic              start
);
  scan_op_e          op_q, op_n;
  logic [DATA_W-1:0] key_q, key_n;
  logic [LEN_W-1:0]  len_q, len_n;
  logic              op_en, key_en, len_en;

  always_comb begin
    op_en  = wr_en && !lock && (wr_addr == A_OP);
    key_en = wr_en && !lock && (wr_addr == A_KEY);
    len_en = wr_en && !lock && (wr_addr == A_LEN);
    op_n   = op_en  ? scan_op_e'(wr_data[1:0]) : op_q;
    key_n  = key_en ? wr_data : key_q;
    len_n  = len_en ? wr_data[LEN_W-1:0] : len_q;
    start  = wr_en && (wr_addr == A_CTRL) && wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_HIT;
      key_q <= '0;
      len_q <= '0;
    end else begin
      op_q  <= op_n;
      key_q <= key_n;
      len_q <= len_n;
    end
  end

  assign op  = op_q;
  assign key = key_q;
  assign len = len_q;

  // R10: configuration is frozen while a scan runs
  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> (key_q == $past(key_q)) && (len_q == $past(len_q)) && (op_q == $past(op_q)));
endmodule

// File: rtl/colscan_ctrl.sv
module colscan_ctrl
  import colscan_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  scan_op_e         op,
  input  logic [LEN_W-1:0] len,
  input  logic             s_valid,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             take,
  output logic             clr
);
  logic             busy_q, busy_n;
  logic             done_q, done_n;
  logic             err_q, err_n;
  logic [LEN_W-1:0] remain_q, remain_n;
  logic             launch, last;

  always_comb begin
    take     = busy_q && s_valid;
    last     = take && (remain_q == LEN_W'(1));
    launch   = start && !busy_q;
    busy_n   = busy_q;
    done_n   = done_q;
    err_n    = err_q;
    remain_n = remain_q;
    if (launch) begin
      done_n = 1'b0;
      err_n  = 1'b0;
      if (op == OP_BAD) begin
        err_n  = 1'b1;
        done_n = 1'b1;
      end else if (len == '0) begin
        done_n = 1'b1;
      end else begin
        busy_n   = 1'b1;
        remain_n = len;
      end
    end else if (take) begin
      remain_n = remain_q - LEN_W'(1);
      if (last) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      remain_q <= '0;
    end else begin
      busy_q   <= busy_n;
      done_q   <= done_n;
      err_q    <= err_n;
      remain_q <= remain_n;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign err  = err_q;
  assign clr  = launch;

  // R8: busy and done never overlap
  a_r8_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && done_q));
  // R8: done follows the last consumed element
  a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> done_q && !busy_q);
  // R5: illegal opcode finishes at once with error
  a_r5_illegal_op: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && op == OP_BAD) |=> (err_q && done_q && !busy_q));
  // R10: start during a scan does not disturb it
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && !take) |=> busy_q && !done_q);
endmodule

// File: rtl/colscan_accum.sv
module colscan_accum
  import colscan_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  scan_op_e          op,
  input  logic [DATA_W-1:0] key,
  input  logic [DATA_W-1:0] data,
  output logic              hit,
  output logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] max
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic              hit_q, hit_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [DATA_W-1:0] max_q, max_n;
  logic              match, hit_en, cnt_en, max_en;

  always_comb begin
    match  = (data == key);
    hit_en = take && (op == OP_HIT) && match;
    cnt_en = take && (op == OP_CNT) && match && (cnt_q != CNT_TOP);
    max_en = take && (op == OP_MAX) && (data > max_q);
    hit_n  = clr ? 1'b0 : (hit_en ? 1'b1 : hit_q);
    cnt_n  = clr ? '0 : (cnt_en ? cnt_q + CNT_W'(1) : cnt_q);
    max_n  = clr ? '0 : (max_en ? data : max_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      cnt_q <= '0;
      max_q <= '0;
    end else begin
      hit_q <= hit_n;
      cnt_q <= cnt_n;
      max_q <= max_n;
    end
  end

  assign hit = hit_q;
  assign cnt = cnt_q;
  assign max = max_q;

  // R2: the hit flag only rises after a matching element in hit mode
  a_r2_hit_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_q) |-> $past(take && op == OP_HIT && data == key));
  // R9: a saturated count holds
  a_r9_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_TOP && !clr) |=> cnt_q == CNT_TOP);
  // R4: the maximum never falls and covers each consumed element
  a_r4_max_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op == OP_MAX && !clr) |=> (max_q >= $past(max_q)) && (max_q >= $past(data)));
endmodule

// File: rtl/colscan_unit.sv
module colscan_unit
  import colscan_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LEN_W  = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_wr_addr,
  input  logic [DATA_W-1:0] reg_wr_data,
  input  logic [2:0]        reg_rd_addr,
  output logic [DATA_W-1:0] reg_rd_data,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready
);
  logic [1:0]        rst_sync;
  logic              rst_int;
  scan_op_e          op;
  logic [DATA_W-1:0] key;
  logic [LEN_W-1:0]  len;
  logic              start, busy, done, err, take, clr, hit;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] max;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int = rst_sync[1];

  colscan_cfg #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_cfg (
    .clk(clk), .rst_n(rst_int), .wr_en(reg_wr_en), .wr_addr(reg_wr_addr),
    .wr_data(reg_wr_data), .lock(busy), .op(op), .key(key), .len(len),
    .start(start)
  );

  colscan_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_int), .start(start), .op(op), .len(len),
    .s_valid(s_valid), .busy(busy), .done(done), .err(err), .take(take),
    .clr(clr)
  );

  colscan_accum #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst_n(rst_int), .clr(clr), .take(take), .op(op), .key(key),
    .data(s_data), .hit(hit), .cnt(cnt), .max(max)
  );

  always_comb begin
    reg_rd_data = '0;
    case (reg_rd_addr)
      A_STAT: reg_rd_data[2:0] = {err, busy, done};
      A_HIT:  reg_rd_data[0] = hit;
      A_CNT:  reg_rd_data[CNT_W-1:0] = cnt;
      A_MAX:  reg_rd_data = max;
      default: reg_rd_data = '0;
    endcase
  end

  assign s_ready = busy;
endmodule

// File: tb/sim_colscan_unit.sv
`timescale 1ns/1ps
module sim_colscan_unit;
  logic        clk, rst_n, wr_en, s_valid;
  logic [2:0]  wr_addr, rd_addr;
  logic [63:0] wr_data, s_data, rd0, rd1;
  logic        rdy0, rdy1;
  int checks, failures;
  bit finished;

  colscan_unit u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_wr_addr(wr_addr),
    .reg_wr_data(wr_data), .reg_rd_addr(rd_addr), .reg_rd_data(rd0),
    .s_valid(s_valid), .s_data(s_data), .s_ready(rdy0)
  );
  colscan_unit #(.CNT_W(2)) u1 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_wr_addr(wr_addr),
    .reg_wr_data(wr_data), .reg_rd_addr(rd_addr), .reg_rd_data(rd1),
    .s_valid(s_valid), .s_data(s_data), .s_ready(rdy1)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [1:0]  op;
    logic [63:0] key;
    logic [2:0]  len;
    logic        gap;
    logic [63:0] e0, e1, e2, e3;
    logic [63:0] exp;
  } vec_t;

  localparam logic [63:0] BIG  = 64'h8000_0000_0000_0001;
  localparam logic [63:0] MID  = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam vec_t VT [7] = '{
    '{op:2'b00, key:64'd5, len:3'd4, gap:1'b0, e0:64'd1, e1:64'd5, e2:64'd9, e3:64'd5, exp:64'd1},
    '{op:2'b00, key:64'd7, len:3'd4, gap:1'b1, e0:64'd1, e1:64'd5, e2:64'd9, e3:64'd5, exp:64'd0},
    '{op:2'b01, key:64'd5, len:3'd4, gap:1'b0, e0:64'd1, e1:64'd5, e2:64'd9, e3:64'd5, exp:64'd2},
    '{op:2'b01, key:64'd5, len:3'd2, gap:1'b1, e0:64'd1, e1:64'd5, e2:64'd5, e3:64'd5, exp:64'd1},
    '{op:2'b10, key:64'd0, len:3'd4, gap:1'b0, e0:64'd3, e1:BIG,   e2:MID,   e3:64'd2, exp:BIG},
    '{op:2'b10, key:64'd0, len:3'd0, gap:1'b0, e0:64'd9, e1:64'd9, e2:64'd9, e3:64'd9, exp:64'd0},
    '{op:2'b00, key:64'd9, len:3'd3, gap:1'b1, e0:64'd1, e1:64'd5, e2:64'd9, e3:64'd0, exp:64'd1}
  };

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] v0, output logic [63:0] v1);
    rd_addr = a;
    #0.5;
    v0 = rd0; v1 = rd1;
  endtask

  task automatic feed(input logic [63:0] d);
    s_valid = 1'b1; s_data = d;
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [63:0] v0, v1;
    logic [63:0] el [4];
    checks = 0; failures = 0; finished = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; s_valid = 1'b0; s_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    rd(3'd4, v0, v1); chk("R11 status", v0, 64'd0);
    rd(3'd5, v0, v1); chk("R11 hit", v0, 64'd0);
    rd(3'd6, v0, v1); chk("R11 count", v0, 64'd0);
    rd(3'd7, v0, v1); chk("R11 max", v0, 64'd0);

    // Table walk: R1 R2 R3 R4 R6 R7 R8 R12
    for (int v = 0; v < 7; v++) begin
      el[0] = VT[v].e0; el[1] = VT[v].e1; el[2] = VT[v].e2; el[3] = VT[v].e3;
      wr(3'd1, {62'd0, VT[v].op});
      wr(3'd2, VT[v].key);
      wr(3'd3, {61'd0, VT[v].len});
      wr(3'd0, 64'd1);
      if (VT[v].len == 3'd0) begin
        rd(3'd4, v0, v1); chk("R6 zero-length done", v0, 64'd1);
      end else begin
        rd(3'd4, v0, v1); chk("R8 busy after start", v0, 64'd2);
        chk("R7 s_ready while busy", {63'd0, rdy0}, 64'd1);
        for (int i = 0; i < int'(VT[v].len); i++) begin
          if (VT[v].gap && i == 1) @(negedge clk);
          if (i == int'(VT[v].len) - 1) begin
            rd(3'd4, v0, v1); chk("R8 not done before last", v0, 64'd2);
          end
          feed(el[i]);
        end
        rd(3'd4, v0, v1); chk("R8 done after last", v0, 64'd1);
        chk("R7 s_ready low after scan", {63'd0, rdy0}, 64'd0);
      end
      rd(3'd5, v0, v1);
      chk("R2 hit result", v0, (VT[v].op == 2'b00) ? VT[v].exp : 64'd0);
      rd(3'd6, v0, v1);
      chk("R3 count result", v0, (VT[v].op == 2'b01) ? VT[v].exp : 64'd0);
      rd(3'd7, v0, v1);
      chk("R4 R1 max result", v0, (VT[v].op == 2'b10) ? VT[v].exp : 64'd0);
    end

    // R5 illegal opcode
    wr(3'd1, 64'd3);
    wr(3'd0, 64'd1);
    rd(3'd4, v0, v1); chk("R5 illegal opcode status", v0, 64'd5);
    chk("R5 no s_ready", {63'd0, rdy0}, 64'd0);

    // R10 start and config writes ignored while busy
    wr(3'd1, 64'd1);
    wr(3'd2, 64'd5);
    wr(3'd3, 64'd4);
    wr(3'd0, 64'd1);
    rd(3'd4, v0, v1); chk("R6 start clears error", v0, 64'd2);
    feed(64'd1);
    feed(64'd5);
    wr(3'd0, 64'd1);
    rd(3'd4, v0, v1); chk("R10 start ignored while busy", v0, 64'd2);
    wr(3'd2, 64'd9);
    wr(3'd3, 64'd1);
    feed(64'd9);
    rd(3'd4, v0, v1); chk("R10 length write ignored", v0, 64'd2);
    feed(64'd5);
    rd(3'd4, v0, v1); chk("R10 done after original length", v0, 64'd1);
    rd(3'd6, v0, v1); chk("R10 key write ignored", v0, 64'd2);

    // R9 count saturation on narrow counter
    wr(3'd2, 64'd0);
    wr(3'd3, 64'd6);
    wr(3'd0, 64'd1);
    for (int i = 0; i < 6; i++) feed(64'd0);
    rd(3'd6, v0, v1);
    chk("R9 wide count", v0, 64'd6);
    chk("R9 narrow count saturates", v1, 64'd3);

    finish_run();
  end
endmodule